// File: doc/BRIEF.md
# Calibration Trim Loader

The block sits behind a control register and turns a bit-banged serial stream into stored 8-bit trim values for a bank of calibration converters. Software toggles one register bit as a serial clock and another as serial data; each rising transition of the clock bit shifts one data bit into an 11-bit frame register. The frame holds a 3-bit channel address in its upper bits and an 8-bit trim value in its lower bits.

A separate 2-bit load-select field then picks which of three eight-channel converters takes the frame. The latch fires once, when that field moves from zero to a nonzero code. Logical trim channels 0 to 20 are spread over the converters eight at a time, so the third converter carries only five channels. All stored trims are offered side by side on one parallel readback bus.

Top module: `caltrim_loader`

## Requirements
- R1: While reset is asserted and after it is released, every trim field of the readback bus reads zero until a latch writes it.
- R2: One data bit is shifted in for each 0-to-1 transition of the serial clock input; holding the clock high over several cycles shifts nothing more, whatever the data input does.
- R3: Frames are sent most significant bit first; of the last 11 bits shifted, the first three form the channel address (bit 10 down to bit 8) and the last eight form the trim value (bit 7 down to bit 0).
- R4: Load-select code 1 writes into the first converter, code 2 into the second and code 3 into the third; code 0 changes nothing.
- R5: Logical channel c equals 8 times the converter index (0, 1 or 2) plus the frame address, and its value appears on readback bits 8c+7 down to 8c.
- R6: A latch happens only on the cycle where the load-select field changes from 0 to nonzero; holding a nonzero code, shifting new bits meanwhile, or moving from one nonzero code to another does not write again.
- R7: The frame register always holds the 11 most recent bits: extra clocks push out the oldest bits, and a latch after fewer than 11 clocks uses whatever the register then holds.
- R8: A latch to the third converter with frame address 5, 6 or 7 leaves every trim unchanged.
- R9: A single latch changes at most one trim channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sdata | input | 1 | Serial data bit from the control register |
| cfg_sclk | input | 1 | Serial clock bit from the control register |
| cfg_load_sel | input | 2 | Load-select code: 0 idle, 1 to 3 pick a converter |
| trim_rd | output | 168 | Trim readback, channel c on bits 8c+7:8c |

## Verification
The assertions assume the three control inputs are synchronous to the block clock and change at most once per cycle, as a register write would; they also take it that a latch cycle never coincides with a serial clock rise, since the latch then sees the frame from before that shift. The stimulus drives every input on the falling clock edge, keeps the load-select field at zero while bits are shifted except in the deliberate hold test, and separates each serial clock rise from a load-select rise by at least one full cycle.

// File: rtl/caltrim_pkg.sv
package caltrim_pkg;

  // Default geometry of the trim bank.
  localparam int TRIM_VAL_W   = 8;
  localparam int TRIM_ADDR_W  = 3;
  localparam int TRIM_CONV_N  = 3;
  localparam int TRIM_USED_CH = 21;

  // Number of channels actually present in converter k.
  function automatic int conv_used(input int k, input int used, input int per);
    int rem;
    rem = used - k * per;
    if (rem > per) rem = per;
    if (rem < 0) rem = 0;
    return rem;
  endfunction

endpackage

// File: rtl/caltrim_rstsync.sv
module caltrim_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/caltrim_shifter.sv
module caltrim_shifter #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdata,
  input  logic               sclk,
  output logic [FRAME_W-1:0] frame
);

  logic               sclk_q;
  logic               sclk_rise;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  // Edge detect on the register-driven serial clock.
  assign sclk_rise = sclk & ~sclk_q;

  // Next state: shift in at the rising transition only.
  always_comb begin
    frame_d = frame_q;
    if (sclk_rise) begin
      frame_d = {frame_q[FRAME_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      sclk_q <= sclk;
      if (sclk_rise) begin
        frame_q <= frame_d;
      end
    end
  end

  assign frame = frame_q;

  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> frame == {$past(frame[FRAME_W-2:0]), $past(sdata)}); // R7

  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(frame)); // R2

endmodule

// File: rtl/caltrim_strobe.sv
module caltrim_strobe #(
  parameter int SEL_W  = 2,
  parameter int CONV_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  output logic [CONV_N-1:0] strobe
);

  logic [SEL_W-1:0] sel_q;
  logic             arm_edge;

  // A write is armed only when the code leaves zero.
  assign arm_edge = (sel_q == '0) && (sel != '0);

  always_comb begin
    strobe = '0;
    for (int k = 0; k < CONV_N; k++) begin
      if (arm_edge && (sel == SEL_W'(k + 1))) begin
        strobe[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R4

  AST_NO_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |=> (strobe == '0)); // R6

endmodule

// File: rtl/caltrim_bank.sv
module caltrim_bank #(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 3,
  parameter int USED   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [VAL_W-1:0]      wdata,
  output logic [USED*VAL_W-1:0] rd
);

  logic [USED-1:0] hit;

  for (genvar i = 0; i < USED; i++) begin : g_ch
    logic [VAL_W-1:0] val_q;
    logic [VAL_W-1:0] val_d;

    // Addresses at or above USED match no channel and are dropped.
    assign hit[i] = we && (addr == ADDR_W'(i));

    always_comb begin
      val_d = val_q;
      if (hit[i]) begin
        val_d = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit[i]) begin
        val_q <= val_d;
      end
    end

    assign rd[i*VAL_W +: VAL_W] = val_q;
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rd)); // R4

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R9

endmodule

// File: rtl/caltrim_loader.sv
module caltrim_loader
  import caltrim_pkg::*;
#(
  parameter int VAL_W   = TRIM_VAL_W,
  parameter int ADDR_W  = TRIM_ADDR_W,
  parameter int CONV_N  = TRIM_CONV_N,
  parameter int USED_CH = TRIM_USED_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_sdata,
  input  logic                     cfg_sclk,
  input  logic [1:0]               cfg_load_sel,
  output logic [USED_CH*VAL_W-1:0] trim_rd
);

  localparam int FRAME_W   = ADDR_W + VAL_W;
  localparam int PER_CONV  = 1 << ADDR_W;
  localparam int SEL_W     = 2;
  localparam int LAST_USED = conv_used(CONV_N - 1, USED_CH, PER_CONV);

  logic               rst_n_int;
  logic [FRAME_W-1:0] frame;
  logic [CONV_N-1:0]  strobe;
  logic [ADDR_W-1:0]  frame_addr;
  logic [VAL_W-1:0]   frame_val;

  caltrim_rstsync #(
    .STAGES(2)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  caltrim_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk  (clk),
    .rst_n(rst_n_int),
    .sdata(cfg_sdata),
    .sclk (cfg_sclk),
    .frame(frame)
  );

  caltrim_strobe #(
    .SEL_W (SEL_W),
    .CONV_N(CONV_N)
  ) u_strobe (
    .clk   (clk),
    .rst_n (rst_n_int),
    .sel   (cfg_load_sel),
    .strobe(strobe)
  );

  // Upper bits address a channel, lower bits carry the value.
  assign frame_addr = frame[FRAME_W-1 -: ADDR_W];
  assign frame_val  = frame[VAL_W-1:0];

  for (genvar k = 0; k < CONV_N; k++) begin : g_conv
    localparam int USED_K = conv_used(k, USED_CH, PER_CONV);
    localparam int BASE   = k * PER_CONV * VAL_W;

    caltrim_bank #(
      .VAL_W (VAL_W),
      .ADDR_W(ADDR_W),
      .USED  (USED_K)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n_int),
      .we   (strobe[k]),
      .addr (frame_addr),
      .wdata(frame_val),
      .rd   (trim_rd[BASE +: USED_K*VAL_W])
    );
  end

  AST_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (strobe[CONV_N-1] && (int'(frame_addr) >= LAST_USED)) |=> $stable(trim_rd)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (strobe == '0) |=> $stable(trim_rd)); // R6

endmodule

// File: tb/caltrim_loader_test.sv
module caltrim_loader_test;

  localparam int VW  = 8;
  localparam int NCH = 21;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              sdata;
  logic              sclk;
  logic [1:0]        sel;
  logic [NCH*VW-1:0] trim;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [10:0]   sr_m;
  logic [VW-1:0] exp_t [NCH];

  caltrim_loader uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sdata   (sdata),
    .cfg_sclk    (sclk),
    .cfg_load_sel(sel),
    .trim_rd     (trim)
  );

  task automatic chk_all(input string req);
    bit bad = 0;
    checks++;
    for (int c = 0; c < NCH; c++) begin
      if (trim[c*VW +: VW] !== exp_t[c]) begin
        $display("FAIL %s: channel %0d actual %02h expected %02h",
                 req, c, trim[c*VW +: VW], exp_t[c]);
        bad = 1;
      end
    end
    if (bad) fails++;
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk) begin sdata = b; sclk = 1'b0; end
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sclk = 1'b0;
    sr_m = {sr_m[9:0], b};
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(bits[i]);
  endtask

  // Expected effect derives from R4, R5 and R8.
  function automatic void model_latch(input logic [1:0] code);
    int ch;
    if (code != 2'd0) begin
      ch = (int'(code) - 1) * 8 + int'(sr_m[10:8]);
      if (ch < NCH) exp_t[ch] = sr_m[7:0];
    end
  endfunction

  task automatic do_latch(input logic [1:0] code);
    @(negedge clk) sel = code;
    @(negedge clk) sel = 2'd0;
    model_latch(code);
    @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; sdata = 1'b0; sclk = 1'b0; sel = 2'd0;
    sr_m = '0;
    for (int c = 0; c < NCH; c++) exp_t[c] = '0;
    repeat (3) @(negedge clk);
    chk_all("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // R3 R5: one frame per converter
    send({21'd0, 3'd2, 8'hA5}, 11); do_latch(2'd1); chk_all("R3 conv0 addr2");
    send({21'd0, 3'd7, 8'h3C}, 11); do_latch(2'd2); chk_all("R5 conv1 addr7");
    send({21'd0, 3'd4, 8'hFF}, 11); do_latch(2'd3); chk_all("R5 conv2 addr4");
    send({21'd0, 3'd0, 8'h11}, 11); do_latch(2'd3); chk_all("R4 conv2 addr0");

    // R4: code 0 does nothing
    send({21'd0, 3'd1, 8'h77}, 11); do_latch(2'd0); chk_all("R4 code zero");

    // R8: unused addresses of the third converter
    send({21'd0, 3'd5, 8'h99}, 11); do_latch(2'd3); chk_all("R8 addr5");
    send({21'd0, 3'd7, 8'h5A}, 11); do_latch(2'd3); chk_all("R8 addr7");

    // R6: hold and code change without returning to zero
    send({21'd0, 3'd3, 8'h42}, 11);
    @(negedge clk) sel = 2'd1;
    model_latch(2'd1);
    repeat (2) @(negedge clk);
    chk_all("R6 first latch");
    send({21'd0, 3'd4, 8'h24}, 11);
    chk_all("R6 hold no relatch");
    @(negedge clk) sel = 2'd2;
    repeat (2) @(negedge clk);
    chk_all("R6 nonzero to nonzero");
    @(negedge clk) sel = 2'd0;
    repeat (2) @(negedge clk);
    chk_all("R6 back to zero");
    do_latch(2'd1); chk_all("R6 relatch after zero");

    // R7: overlong and short frames
    send(32'h3A5C, 14); do_latch(2'd2); chk_all("R7 fourteen bits");
    send(32'h16, 5);    do_latch(2'd1); chk_all("R7 five bits");

    // R2: clock held high while data toggles
    @(negedge clk) begin sdata = 1'b1; sclk = 1'b0; end
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sdata = 1'b0;
    @(negedge clk) sdata = 1'b1;
    @(negedge clk) sdata = 1'b0;
    @(negedge clk) sclk = 1'b0;
    sr_m = {sr_m[9:0], 1'b1};
    send({22'd0, 2'b01, 8'h5E}, 10); do_latch(2'd2); chk_all("R2 single shift");

    // R9 R5: random frames, lengths and codes
    for (int it = 0; it < 60; it++) begin
      int n;
      logic [31:0] bits;
      logic [1:0] code;
      n    = $urandom_range(14, 8);
      bits = $urandom;
      code = 2'($urandom_range(3, 0));
      send(bits, n);
      do_latch(code);
      chk_all("R9 random latch");
    end

    done = 1;
    report();
  end

endmodule